// File: doc/BRIEF.md
# Audio Link Control and Interrupt Register Bank

This block is the register bank that sits between a processor and the datapath of a two-channel digital audio link. Software reaches it through a plain 32-bit register port: one write strobe with an address and write data, and a combinational read data bus driven from the current address. The bank holds the datapath controls: a run enable, a FIFO flush request and a 4-bit clock-ratio code. It passes these to the datapath on dedicated pins.

The datapath reports a channel-status update as a one-cycle strobe. It supplies a channel-status word and a user-data word with that strobe, and the bank captures both. The strobe sets a sticky pending flag. Software clears the flag by writing 1 to it. A registered level interrupt rises only when the pending flag, its per-source enable and a master enable held in a separate register are all set. Software can mask the source alone and leave the event pending.

Writing a fixed key to the reset register returns the control, enable, pending and captured state to zero. It also sends a one-cycle reset pulse to the datapath. Any other value written to that register does nothing.

Top module: `aud_ctl_regs`

## Requirements
- R1: After rst_n is released, every output is 0 and every mapped register reads 0.
- R2: A write to offset 0x44 sets core_en from data bit 0 and clk_cfg from data bits 5:2. A read of 0x44 returns {26'b0, clk_cfg, flush, core_en}.
- R3: Writing 1 to bit 1 of 0x44 drives fifo_flush high for exactly one cycle after the write edge. Readback bit 1 then returns to 0 by itself, and the other control fields are not disturbed.
- R4: A cs_evt strobe sets the pending flag at bit 5 of offset 0x20. Writing 1 to bit 5 clears it. Writing 0 leaves it set.
- R5: If cs_evt and a write-1 clear of bit 5 happen on the same edge, the flag ends set.
- R6: irq is registered. On the edge after the pending flag (0x20 bit 5), the source enable (0x28 bit 5) and the master enable (0x1C bit 31) are all 1, it goes high. When any of the three is 0, it is low on the next edge.
- R7: Clearing the source enable at 0x28 drops irq and leaves the pending flag set. Only bit 5 of 0x20 and 0x28 and bit 31 of 0x1C are implemented; the other bits read 0.
- R8: Writing exactly 0xA to offset 0x40 clears control, source enable, master enable, pending flag and captured words on that edge, and pulses core_srst for one cycle. Any other value changes nothing, and core_srst stays low.
- R9: Offset 0x40 and every unmapped offset read 0. Writes to unmapped offsets change no register.
- R10: On each cs_evt, cs_word and ud_word are captured. They read back at offsets 0x4C and 0x64 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| cs_evt | input | 1 | One-cycle channel-status update strobe |
| cs_word | input | 32 | Channel-status word, captured on cs_evt |
| ud_word | input | 32 | User-data word, captured on cs_evt |
| core_en | output | 1 | Datapath run enable |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| clk_cfg | output | 4 | Clock-ratio code |
| core_srst | output | 1 | One-cycle datapath reset pulse |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following:
- the one-cycle width of the flush pulse;
- that a same-edge set beats a clear;
- that a write-1 clear empties the flag;
- that irq follows the AND of flag and enables one edge later;
- that the reset key clears the bank and pulses core_srst, and that nothing else pulses it;
- that a control write lands on the outputs.

Only the bench's sweeps can show the rest: the readback layout of each register, the full 16-value key sweep, the eight-way interrupt truth table, the writes scattered over every unmapped offset, and the captured-word readback.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;
  localparam logic [7:0] OFS_GIE   = 8'h1C;
  localparam logic [7:0] OFS_ISR   = 8'h20;
  localparam logic [7:0] OFS_IER   = 8'h28;
  localparam logic [7:0] OFS_SRST  = 8'h40;
  localparam logic [7:0] OFS_CTRL  = 8'h44;
  localparam logic [7:0] OFS_CSTAT = 8'h4C;
  localparam logic [7:0] OFS_UDATA = 8'h64;

  localparam int          EVT_BIT  = 5;
  localparam int          GIE_BIT  = 31;
  localparam logic [31:0] SRST_KEY = 32'h0000_000A;

  typedef struct packed {
    logic [3:0] clk_cfg;
    logic       flush;
    logic       core_en;
  } ctrl_t;
endpackage

// File: rtl/aud_ctl_bank.sv
module aud_ctl_bank
  import aud_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       wr_ctrl,
  input  logic [5:0] wdata,
  output ctrl_t      ctrl
);
  // flush is a request bit: it lives exactly one cycle after being written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (srst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl <= ctrl_t'(wdata);
    end else begin
      ctrl.flush <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_irq_unit.sv
module aud_irq_unit #(
  parameter int          DW        = 32,
  parameter logic [31:0] IMPL_MASK = 32'h0000_0020,
  parameter int          GIE_POS   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          wr_isr,
  input  logic          wr_ier,
  input  logic          wr_gie,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] isr_q,
  output logic [DW-1:0] ier_q,
  output logic          gie_q,
  output logic          irq
);
  localparam logic [DW-1:0] MASK = DW'(IMPL_MASK);

  logic [DW-1:0] set_v, clr_v, isr_d;

  assign set_v = evt & MASK;
  assign clr_v = wr_isr ? (wdata & MASK) : '0;
  // set has priority over a same-cycle clear
  assign isr_d = set_v | (isr_q & ~clr_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      ier_q <= '0;
      gie_q <= 1'b0;
      irq   <= 1'b0;
    end else if (srst) begin
      isr_q <= '0;
      ier_q <= '0;
      gie_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      isr_q <= isr_d;
      if (wr_ier) ier_q <= wdata & MASK;
      if (wr_gie) gie_q <= wdata[GIE_POS];
      irq <= gie_q & (|(isr_q & ier_q));
    end
  end
endmodule

// File: rtl/aud_cap_regs.sv
module aud_cap_regs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          evt,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] ud_in,
  output logic [DW-1:0] cs_q,
  output logic [DW-1:0] ud_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0;
      ud_q <= '0;
    end else if (srst) begin
      cs_q <= '0;
      ud_q <= '0;
    end else if (evt) begin
      cs_q <= cs_in;
      ud_q <= ud_in;
    end
  end
endmodule

// File: rtl/aud_ctl_regs.sv
module aud_ctl_regs
  import aud_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cs_evt,
  input  logic [31:0]       cs_word,
  input  logic [31:0]       ud_word,
  output logic              core_en,
  output logic              fifo_flush,
  output logic [3:0]        clk_cfg,
  output logic              core_srst,
  output logic              irq
);
  localparam int          DW        = 32;
  localparam logic [31:0] IMPL_MASK = 32'h1 << EVT_BIT;

  localparam logic [ADDR_W-1:0] A_GIE   = ADDR_W'(OFS_GIE);
  localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFS_ISR);
  localparam logic [ADDR_W-1:0] A_IER   = ADDR_W'(OFS_IER);
  localparam logic [ADDR_W-1:0] A_SRST  = ADDR_W'(OFS_SRST);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CSTAT = ADDR_W'(OFS_CSTAT);
  localparam logic [ADDR_W-1:0] A_UDATA = ADDR_W'(OFS_UDATA);

  logic          srst_hit;
  logic          wr_ctrl, wr_isr, wr_ier, wr_gie;
  ctrl_t         ctrl;
  logic [DW-1:0] isr_v, ier_v, evt_v, cs_q, ud_q;
  logic          gie_b;
  logic          srst_q;

  assign srst_hit = reg_wr && (reg_addr == A_SRST) && (reg_wdata == SRST_KEY);
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_isr   = reg_wr && (reg_addr == A_ISR);
  assign wr_ier   = reg_wr && (reg_addr == A_IER);
  assign wr_gie   = reg_wr && (reg_addr == A_GIE);
  assign evt_v    = DW'(cs_evt) << EVT_BIT;

  aud_ctl_bank u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .srst    (srst_hit),
    .wr_ctrl (wr_ctrl),
    .wdata   (reg_wdata[5:0]),
    .ctrl    (ctrl)
  );

  aud_irq_unit #(.DW(DW), .IMPL_MASK(IMPL_MASK), .GIE_POS(GIE_BIT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst   (srst_hit),
    .wr_isr (wr_isr),
    .wr_ier (wr_ier),
    .wr_gie (wr_gie),
    .wdata  (reg_wdata),
    .evt    (evt_v),
    .isr_q  (isr_v),
    .ier_q  (ier_v),
    .gie_q  (gie_b),
    .irq    (irq)
  );

  aud_cap_regs #(.DW(DW)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .srst  (srst_hit),
    .evt   (cs_evt),
    .cs_in (cs_word),
    .ud_in (ud_word),
    .cs_q  (cs_q),
    .ud_q  (ud_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_hit;
  end

  assign core_srst  = srst_q;
  assign core_en    = ctrl.core_en;
  assign fifo_flush = ctrl.flush;
  assign clk_cfg    = ctrl.clk_cfg;

  always_comb begin
    unique case (reg_addr)
      A_GIE:   reg_rdata = {gie_b, 31'b0};
      A_ISR:   reg_rdata = isr_v;
      A_IER:   reg_rdata = ier_v;
      A_CTRL:  reg_rdata = {26'b0, ctrl};
      A_CSTAT: reg_rdata = cs_q;
      A_UDATA: reg_rdata = ud_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aud_ctl_regs_chk.sv
module aud_ctl_regs_chk
  import aud_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              cs_evt,
  input logic              core_en,
  input logic              fifo_flush,
  input logic [3:0]        clk_cfg,
  input logic              core_srst,
  input logic              irq,
  input logic [31:0]       isr_v,
  input logic [31:0]       ier_v,
  input logic              gie_b
);
  logic key_wr, isr_clr, ctrl_wr;
  assign key_wr  = reg_wr && reg_addr == ADDR_W'(OFS_SRST) && reg_wdata == SRST_KEY;
  assign isr_clr = reg_wr && reg_addr == ADDR_W'(OFS_ISR) && reg_wdata[EVT_BIT];
  assign ctrl_wr = reg_wr && reg_addr == ADDR_W'(OFS_CTRL);

  a_r3_flush_single: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> !fifo_flush);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_evt && !key_wr) |=> isr_v[EVT_BIT]);

  a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_clr && !cs_evt) |=> !isr_v[EVT_BIT]);

  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> irq == $past(isr_v[EVT_BIT] && ier_v[EVT_BIT] && gie_b));

  a_r8_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (core_srst && !core_en && clk_cfg == 4'd0 && !isr_v[EVT_BIT]
                && !ier_v[EVT_BIT] && !gie_b && !irq));

  a_r8_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> !core_srst);

  a_r2_ctrl_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (core_en == $past(reg_wdata[0]) && clk_cfg == $past(reg_wdata[5:2])));
endmodule

bind aud_ctl_regs aud_ctl_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .cs_evt     (cs_evt),
  .core_en    (core_en),
  .fifo_flush (fifo_flush),
  .clk_cfg    (clk_cfg),
  .core_srst  (core_srst),
  .irq        (irq),
  .isr_v      (isr_v),
  .ier_v      (ier_v),
  .gie_b      (gie_b)
);

// File: tb/test_aud_ctl_regs.sv
module test_aud_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cs_evt = 1'b0;
  logic [31:0] cs_word = '0;
  logic [31:0] ud_word = '0;
  logic        core_en, fifo_flush, core_srst, irq;
  logic [3:0]  clk_cfg;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  aud_ctl_regs #(.ADDR_W(8)) i_aud_ctl_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cs_evt(cs_evt),
    .cs_word(cs_word), .ud_word(ud_word), .core_en(core_en),
    .fifo_flush(fifo_flush), .clk_cfg(clk_cfg), .core_srst(core_srst), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, returns one falling edge later (write edge passed)
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [31:0] cw, input logic [31:0] uw);
    @(negedge clk);
    cs_evt = 1'b1; cs_word = cw; ud_word = uw;
    @(negedge clk);
    cs_evt = 1'b0;
  endtask

  task automatic key_reset();
    wr(8'h40, 32'hA);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  mapped [7];
    mapped = '{8'h1C, 8'h20, 8'h28, 8'h40, 8'h44, 8'h4C, 8'h64};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 core_en", 32'(core_en), 0);
    check("R1 fifo_flush", 32'(fifo_flush), 0);
    check("R1 clk_cfg", 32'(clk_cfg), 0);
    check("R1 core_srst", 32'(core_srst), 0);
    check("R1 irq", 32'(irq), 0);
    foreach (mapped[i]) begin rd(mapped[i], v); check("R1 mapped read", v, 0); end

    // R2 sweep of clock code and enable
    for (int c = 0; c < 16; c++) begin
      for (int e = 0; e < 2; e++) begin
        wr(8'h44, (32'(c) << 2) | 32'(e));
        check("R2 clk_cfg", 32'(clk_cfg), 32'(c));
        check("R2 core_en", 32'(core_en), 32'(e));
        rd(8'h44, v);
        check("R2 readback", v, (32'(c) << 2) | 32'(e));
      end
    end

    // R3 flush pulse self-clears
    wr(8'h44, 32'h27);  // cfg 9, flush, enable
    check("R3 flush high", 32'(fifo_flush), 1);
    rd(8'h44, v); check("R3 readback flush set", v, 32'h27);
    @(negedge clk);
    check("R3 flush low", 32'(fifo_flush), 0);
    rd(8'h44, v); check("R3 readback flush cleared", v, 32'h25);
    check("R3 enable kept", 32'(core_en), 1);

    // R4 / R10 set, capture, write-0 no effect, write-1 clear
    pulse_evt(32'hCAFE_0123, 32'h0BAD_F00D);
    rd(8'h20, v); check("R4 flag set", v, 32'h20);
    rd(8'h4C, v); check("R10 status word", v, 32'hCAFE_0123);
    rd(8'h64, v); check("R10 user word", v, 32'h0BAD_F00D);
    wr(8'h20, 32'hFFFF_FFDF);
    rd(8'h20, v); check("R4 write0 keeps", v, 32'h20);
    wr(8'h20, 32'h20);
    rd(8'h20, v); check("R4 write1 clears", v, 0);
    rd(8'h4C, v); check("R10 word held", v, 32'hCAFE_0123);

    // R5 simultaneous set and clear
    pulse_evt(32'h1, 32'h2);
    @(negedge clk);
    cs_evt = 1'b1; cs_word = 32'h55; ud_word = 32'h66;
    reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h20;
    @(negedge clk);
    cs_evt = 1'b0; reg_wr = 1'b0;
    rd(8'h20, v); check("R5 set wins", v, 32'h20);
    rd(8'h4C, v); check("R10 recapture", v, 32'h55);

    // R6 truth table over flag / enable / master
    for (int k = 0; k < 8; k++) begin
      logic s, e, g;
      s = k[0]; e = k[1]; g = k[2];
      key_reset();
      if (e) wr(8'h28, 32'hFFFF_FFFF);
      if (g) wr(8'h1C, 32'h8000_0000);
      if (s) pulse_evt(32'h0, 32'h0);
      else   @(negedge clk);
      check("R6 irq lag", 32'(irq), (s && e && g && 0) ? 1 : (s ? 0 : 32'(e && g && s)));
      @(negedge clk);
      check("R6 irq level", 32'(irq), 32'(s && e && g));
    end

    // R7 mask keeps pending, implemented bits only
    rd(8'h28, v); check("R7 enable bits", v, 32'h20);
    rd(8'h1C, v); check("R7 master bits", v, 32'h8000_0000);
    wr(8'h28, 32'h0);
    @(negedge clk);
    check("R7 irq dropped", 32'(irq), 0);
    rd(8'h20, v); check("R7 still pending", v, 32'h20);

    // R8 key sweep
    for (int k = 0; k < 16; k++) begin
      key_reset();
      wr(8'h44, 32'h3D);
      wr(8'h28, 32'h20);
      wr(8'h1C, 32'h8000_0000);
      pulse_evt(32'h77, 32'h88);
      wr(8'h40, 32'(k));
      check("R8 pulse", 32'(core_srst), 32'(k == 10));
      rd(8'h44, v); check("R8 control", v, (k == 10) ? 0 : 32'h3D);
      rd(8'h20, v); check("R8 flag", v, (k == 10) ? 0 : 32'h20);
      rd(8'h28, v); check("R8 enable", v, (k == 10) ? 0 : 32'h20);
      rd(8'h4C, v); check("R8 captured", v, (k == 10) ? 0 : 32'h77);
      @(negedge clk);
      check("R8 pulse width", 32'(core_srst), 0);
    end

    // R9 unmapped offsets
    key_reset();
    wr(8'h44, 32'h15);
    for (int a = 0; a < 256; a += 4) begin
      bit hit;
      hit = 1'b0;
      foreach (mapped[i]) if (mapped[i] == 8'(a)) hit = 1'b1;
      if (!hit) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rd(8'(a), v); check("R9 unmapped read", v, 0);
      end
    end
    rd(8'h40, v); check("R9 reset reg reads 0", v, 0);
    rd(8'h44, v); check("R9 control untouched", v, 32'h15);
    rd(8'h28, v); check("R9 enable untouched", v, 0);
    rd(8'h1C, v); check("R9 master untouched", v, 0);
    check("R9 no irq", 32'(irq), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule